// File: doc/BRIEF.md
# Serial Port Interrupt Combiner

This block sits beside the shift engine of a serial peripheral and turns its status signals into three level-sensitive interrupt requests: one for receive, one for transmit and one general. The shift engine supplies live status levels (overflow, underrun, full and empty indications, frame error, busy, shift register empty) and the occupancy counts of its receive and transmit FIFOs. The block compares the two counts with thresholds that software programs, so the FIFO watermarks become two more event sources.

Each of the eleven sources has its own enable bit in a mask register. A request line is the OR of the enabled sources in its group, registered once. Software sets the mask and the two thresholds through a small register bus with a combinational read path. After reset every enable and both thresholds are zero, so no line can assert until software sets a mask bit.

Top module: `spi_irq_agg`

## Requirements
- R1: After reset, `rx_irq_o`, `tx_irq_o` and `gen_irq_o` are low, and the mask (address 0), receive threshold (address 1) and transmit threshold (address 2) all read back as zero.
- R2: A write with `reg_we_i` high stores `reg_wdata_i` at the selected address on that clock edge. Mask bits [10:0] and threshold bits [CNT_W-1:0] are stored. Higher write bits are dropped and read back as zero. Address 3 stores nothing and reads as zero.
- R3: The receive watermark event is true when `rx_count_i` is greater than or equal to the receive threshold.
- R4: The transmit watermark event is true when `tx_count_i` is less than or equal to the transmit threshold.
- R5: `rx_irq_o` is the OR of these sources, each ANDed with its mask bit: receive watermark (bit 0), `rx_ovf_i` (bit 1), `rx_full_i` (bit 2), `rx_empty_i` (bit 3).
- R6: `tx_irq_o` is the OR of these sources, each ANDed with its mask bit: transmit watermark (bit 4), `tx_unr_i` (bit 5), `tx_full_i` (bit 6), `tx_empty_i` (bit 7).
- R7: `gen_irq_o` is the OR of these sources, each ANDed with its mask bit: `frm_err_i` (bit 8), `busy_i` (bit 9), `sr_empty_i` (bit 10).
- R8: A source whose mask bit is clear has no effect on any output, whatever its level.
- R9: Each output shows the sources and mask present before a clock edge just after that edge: a latency of one cycle. A mask write therefore affects the outputs from the edge after the one that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| rx_count_i | input | CNT_W (5) | Receive FIFO occupancy |
| tx_count_i | input | CNT_W (5) | Transmit FIFO occupancy |
| rx_ovf_i | input | 1 | Receive overflow level |
| rx_full_i | input | 1 | Receive buffer full level |
| rx_empty_i | input | 1 | Receive buffer empty level |
| tx_unr_i | input | 1 | Transmit underrun level |
| tx_full_i | input | 1 | Transmit buffer full level |
| tx_empty_i | input | 1 | Transmit buffer empty level |
| frm_err_i | input | 1 | Frame error level |
| busy_i | input | 1 | Engine busy level |
| sr_empty_i | input | 1 | Shift register empty level |
| rx_irq_o | output | 1 | Receive interrupt request |
| tx_irq_o | output | 1 | Transmit interrupt request |
| gen_irq_o | output | 1 | General interrupt request |

## Verification
If a mask bit is stored wrongly, or one source is routed to the wrong group, one request line is wrong one cycle after that source changes. Random mixes of mask, thresholds and source levels show this, because each sample compares all three lines with an independent model. A comparison that is off by one shows only when a count equals its threshold, so directed cases cover the equal, one-above and one-below counts, and also a threshold of zero and the full depth. A fault in the register path shows at once on read-back, and also one cycle after the next source change.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int unsigned REG_DW  = 32;
    localparam int unsigned ADDR_W  = 2;
    localparam int unsigned N_SRC   = 11;

    // register addresses
    localparam logic [ADDR_W-1:0] ADDR_MASK  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_RXWM  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_TXWM  = 2'd2;

    // group boundaries inside the mask register
    localparam int unsigned RX_LO  = 0;
    localparam int unsigned RX_N   = 4;
    localparam int unsigned TX_LO  = 4;
    localparam int unsigned TX_N   = 4;
    localparam int unsigned GEN_LO = 8;
    localparam int unsigned GEN_N  = 3;

    typedef enum logic {
        CMP_AT_LEAST = 1'b0,
        CMP_AT_MOST  = 1'b1
    } cmp_kind_e;

endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
    import spi_irq_pkg::*;
#(
    parameter int unsigned CNT_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_DW-1:0] wdata_i,
    output logic [REG_DW-1:0] rdata_o,
    output logic [N_SRC-1:0]  mask_o,
    output logic [CNT_W-1:0]  rx_wm_o,
    output logic [CNT_W-1:0]  tx_wm_o
);

    typedef struct packed {
        logic [N_SRC-1:0] mask;
        logic [CNT_W-1:0] rx_wm;
        logic [CNT_W-1:0] tx_wm;
    } regs_t;

    regs_t regs_d, regs_q;

    logic unused_wdata;
    assign unused_wdata = ^wdata_i[REG_DW-1:N_SRC];

    always_comb begin
        regs_d = regs_q;
        if (we_i) begin
            unique case (addr_i)
                ADDR_MASK: regs_d.mask  = wdata_i[N_SRC-1:0];
                ADDR_RXWM: regs_d.rx_wm = wdata_i[CNT_W-1:0];
                ADDR_TXWM: regs_d.tx_wm = wdata_i[CNT_W-1:0];
                default:   regs_d       = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            ADDR_MASK: rdata_o[N_SRC-1:0] = regs_q.mask;
            ADDR_RXWM: rdata_o[CNT_W-1:0] = regs_q.rx_wm;
            ADDR_TXWM: rdata_o[CNT_W-1:0] = regs_q.tx_wm;
            default:   rdata_o            = '0;
        endcase
    end

    assign mask_o  = regs_q.mask;
    assign rx_wm_o = regs_q.rx_wm;
    assign tx_wm_o = regs_q.tx_wm;

    AST_MASK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(we_i) |-> $stable(mask_o)); // R2
    AST_SPARE_ADDR_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(addr_i) == 2'd3) |-> ($stable(mask_o) && $stable(rx_wm_o) && $stable(tx_wm_o))); // R2

endmodule

// File: rtl/irq_wm_cmp.sv
module irq_wm_cmp
    import spi_irq_pkg::*;
#(
    parameter int unsigned CNT_W = 5,
    parameter cmp_kind_e   KIND  = CMP_AT_LEAST
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] level_i,
    output logic             hit_o
);

    generate
        if (KIND == CMP_AT_LEAST) begin : g_ge
            assign hit_o = (count_i >= level_i);
        end else begin : g_le
            assign hit_o = (count_i <= level_i);
        end
    endgenerate

endmodule

// File: rtl/irq_line.sv
module irq_line #(
    parameter int unsigned N = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] en_i,
    output logic         irq_o
);

    typedef struct packed {
        logic irq;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d     = line_q;
        line_d.irq = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (src_i[i] && en_i[i]) line_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) line_q <= '0;
        else         line_q <= line_d;
    end

    assign irq_o = line_q.irq;

    AST_LINE_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ($past(en_i) != '0)); // R8
    AST_LINE_FOLLOWS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (($past(src_i) & $past(en_i)) != '0) |-> irq_o); // R9

endmodule

// File: rtl/spi_irq_agg.sv
module spi_irq_agg
    import spi_irq_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 16,
    localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_DW-1:0] reg_wdata_i,
    output logic [REG_DW-1:0] reg_rdata_o,
    input  logic [CNT_W-1:0]  rx_count_i,
    input  logic [CNT_W-1:0]  tx_count_i,
    input  logic              rx_ovf_i,
    input  logic              rx_full_i,
    input  logic              rx_empty_i,
    input  logic              tx_unr_i,
    input  logic              tx_full_i,
    input  logic              tx_empty_i,
    input  logic              frm_err_i,
    input  logic              busy_i,
    input  logic              sr_empty_i,
    output logic              rx_irq_o,
    output logic              tx_irq_o,
    output logic              gen_irq_o
);

    logic [N_SRC-1:0] mask_q;
    logic [CNT_W-1:0] rx_wm_q;
    logic [CNT_W-1:0] tx_wm_q;
    logic             rx_wm_hit;
    logic             tx_wm_hit;
    logic [N_SRC-1:0] src;

    irq_regfile #(.CNT_W(CNT_W)) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (reg_we_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .rdata_o (reg_rdata_o),
        .mask_o  (mask_q),
        .rx_wm_o (rx_wm_q),
        .tx_wm_o (tx_wm_q)
    );

    irq_wm_cmp #(.CNT_W(CNT_W), .KIND(CMP_AT_LEAST)) u_rx_cmp (
        .count_i (rx_count_i),
        .level_i (rx_wm_q),
        .hit_o   (rx_wm_hit)
    );

    irq_wm_cmp #(.CNT_W(CNT_W), .KIND(CMP_AT_MOST)) u_tx_cmp (
        .count_i (tx_count_i),
        .level_i (tx_wm_q),
        .hit_o   (tx_wm_hit)
    );

    // source order matches mask bit order
    assign src = {sr_empty_i, busy_i, frm_err_i,
                  tx_empty_i, tx_full_i, tx_unr_i, tx_wm_hit,
                  rx_empty_i, rx_full_i, rx_ovf_i, rx_wm_hit};

    irq_line #(.N(RX_N)) u_rx_line (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .src_i  (src[RX_LO +: RX_N]),
        .en_i   (mask_q[RX_LO +: RX_N]),
        .irq_o  (rx_irq_o)
    );

    irq_line #(.N(TX_N)) u_tx_line (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .src_i  (src[TX_LO +: TX_N]),
        .en_i   (mask_q[TX_LO +: TX_N]),
        .irq_o  (tx_irq_o)
    );

    irq_line #(.N(GEN_N)) u_gen_line (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .src_i  (src[GEN_LO +: GEN_N]),
        .en_i   (mask_q[GEN_LO +: GEN_N]),
        .irq_o  (gen_irq_o)
    );

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_q == '0 && $past(mask_q) == '0) |-> !(rx_irq_o || tx_irq_o || gen_irq_o)); // R1
    AST_RX_WATERMARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(mask_q[0]) && ($past(rx_count_i) >= $past(rx_wm_q))) |-> rx_irq_o); // R3
    AST_TX_WATERMARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(mask_q[4]) && ($past(tx_count_i) <= $past(tx_wm_q))) |-> tx_irq_o); // R4
    AST_RX_OVF_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(mask_q[1]) && $past(rx_ovf_i)) |-> rx_irq_o); // R5
    AST_TX_UNR_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(mask_q[5]) && $past(tx_unr_i)) |-> tx_irq_o); // R6
    AST_GEN_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gen_irq_o |-> (($past(mask_q[8]) && $past(frm_err_i)) ||
                       ($past(mask_q[9]) && $past(busy_i)) ||
                       ($past(mask_q[10]) && $past(sr_empty_i)))); // R7

endmodule

// File: tb/tb_spi_irq_agg.sv
module tb_spi_irq_agg;

    localparam int DEPTH = 16;
    localparam int CW    = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [CW-1:0] rxc = '0, txc = '0;
    logic [8:0]  lv = '0; // {sr_empty,busy,frm_err,tx_empty,tx_full,tx_unr,rx_empty,rx_full,rx_ovf}
    logic        rx_irq, tx_irq, gen_irq;

    int n_chk = 0, n_bad = 0;
    logic [10:0]   m_mask = '0;
    logic [CW-1:0] m_rxwm = '0, m_txwm = '0;

    always #4 clk = ~clk;

    spi_irq_agg dut (
        .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .rx_count_i(rxc), .tx_count_i(txc),
        .rx_ovf_i(lv[0]), .rx_full_i(lv[1]), .rx_empty_i(lv[2]),
        .tx_unr_i(lv[3]), .tx_full_i(lv[4]), .tx_empty_i(lv[5]),
        .frm_err_i(lv[6]), .busy_i(lv[7]), .sr_empty_i(lv[8]),
        .rx_irq_o(rx_irq), .tx_irq_o(tx_irq), .gen_irq_o(gen_irq)
    );

    function automatic logic [2:0] model(input logic [10:0] m, input logic [CW-1:0] rw,
                                         input logic [CW-1:0] tw, input logic [CW-1:0] rc,
                                         input logic [CW-1:0] tc, input logic [8:0] l);
        logic r, t, g;
        r = (m[0] && rc >= rw) || (m[1] && l[0]) || (m[2] && l[1]) || (m[3] && l[2]);
        t = (m[4] && tc <= tw) || (m[5] && l[3]) || (m[6] && l[4]) || (m[7] && l[5]);
        g = (m[8] && l[6]) || (m[9] && l[7]) || (m[10] && l[8]);
        return {g, t, r};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
        if (a == 2'd0) m_mask = d[10:0];
        if (a == 2'd1) m_rxwm = d[CW-1:0];
        if (a == 2'd2) m_txwm = d[CW-1:0];
    endtask

    task automatic rd(input string req, input logic [1:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    // drive sources at a falling edge, check one rising edge later
    task automatic apply(input string req, input logic [CW-1:0] rc, input logic [CW-1:0] tc,
                         input logic [8:0] l);
        rxc = rc; txc = tc; lv = l;
        @(negedge clk);
        chk(req, {29'd0, gen_irq, tx_irq, rx_irq},
            {29'd0, model(m_mask, m_rxwm, m_txwm, rc, tc, l)});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        lv = 9'h1FF; rxc = 5'd16; txc = 5'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state with every source active
        chk("R1 irq", {29'd0, gen_irq, tx_irq, rx_irq}, 32'd0);
        rd("R1 mask", 2'd0, 32'd0);
        rd("R1 rxwm", 2'd1, 32'd0);
        rd("R1 txwm", 2'd2, 32'd0);

        // R2: storage widths and spare address
        wr(2'd0, 32'hFFFF_FFFF); rd("R2 mask", 2'd0, 32'h7FF);
        wr(2'd1, 32'hFFFF_FFE7); rd("R2 rxwm", 2'd1, 32'h07);
        wr(2'd2, 32'h0000_0123); rd("R2 txwm", 2'd2, 32'h03);
        wr(2'd3, 32'hFFFF_FFFF);
        rd("R2 spare", 2'd3, 32'd0);
        rd("R2 mask kept", 2'd0, 32'h7FF);
        rd("R2 txwm kept", 2'd2, 32'h03);

        // R9: mask write visible one edge after it is stored
        wr(2'd0, 32'h0);
        lv = 9'h001; rxc = 0; txc = 5'd10;
        @(negedge clk);
        chk("R9 masked", {31'd0, rx_irq}, 32'd0);
        @(negedge clk);
        we = 1'b1; addr = 2'd0; wdata = 32'h002;
        @(negedge clk);
        we = 1'b0; m_mask = 11'h002;
        chk("R9 old mask at store edge", {31'd0, rx_irq}, 32'd0);
        @(negedge clk);
        chk("R9 new mask next edge", {31'd0, rx_irq}, 32'd1);
        lv = 9'h000;
        @(negedge clk);
        chk("R9 drop after one cycle", {31'd0, rx_irq}, 32'd0);

        // R3 boundaries: threshold 7
        wr(2'd0, 32'h001); wr(2'd1, 32'd7);
        apply("R3 below", 5'd6, 5'd0, 9'h0);
        apply("R3 equal", 5'd7, 5'd0, 9'h0);
        apply("R3 above", 5'd8, 5'd0, 9'h0);
        wr(2'd1, 32'd0);
        apply("R3 zero threshold", 5'd0, 5'd0, 9'h0);
        wr(2'd1, 32'd16);
        apply("R3 full threshold below", 5'd15, 5'd0, 9'h0);
        apply("R3 full threshold at", 5'd16, 5'd0, 9'h0);

        // R4 boundaries: threshold 4
        wr(2'd0, 32'h010); wr(2'd2, 32'd4);
        apply("R4 below", 5'd0, 5'd3, 9'h0);
        apply("R4 equal", 5'd0, 5'd4, 9'h0);
        apply("R4 above", 5'd0, 5'd5, 9'h0);
        wr(2'd2, 32'd0);
        apply("R4 zero threshold empty", 5'd0, 5'd0, 9'h0);
        apply("R4 zero threshold one", 5'd0, 5'd1, 9'h0);

        // R5..R7 and R8: walk each mask bit alone against all-active and all-idle sources
        wr(2'd1, 32'd0); wr(2'd2, 32'd16);
        for (int b = 0; b < 11; b++) begin
            wr(2'd0, 32'd1 << b);
            apply(b < 4 ? "R5 single source" : (b < 8 ? "R6 single source" : "R7 single source"),
                  5'd0, 5'd0, 9'h1FF);
        end
        wr(2'd1, 32'd16); wr(2'd2, 32'd0);
        for (int b = 0; b < 11; b++) begin
            wr(2'd0, 32'h7FF ^ (32'd1 << b));
            apply("R8 others disabled", 5'd0, 5'd5, 9'h0);
        end
        wr(2'd0, 32'h0);
        apply("R8 all masked", 5'd16, 5'd0, 9'h1FF);

        // random mix
        for (int i = 0; i < 300; i++) begin
            if (i % 10 == 0) begin
                wr(2'd0, $urandom);
                wr(2'd1, $urandom % (DEPTH + 1));
                wr(2'd2, $urandom % (DEPTH + 1));
            end
            apply("R5 R6 R7 R8 random", CW'($urandom % (DEPTH + 1)),
                  CW'($urandom % (DEPTH + 1)), 9'($urandom));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule